// File: doc/BRIEF.md
# Display RAM Access Arbiter

This block guards a single-port, row-organised frame memory inside a display driver. Two clients share it: a host port that writes or reads one word at a time, and a display port that fetches whole rows (lines) for panel refresh. Each client has its own address input and its own request/acknowledge pair. A one-entry hold register per client captures a request even while the array is busy. The arbiter launches held requests one at a time, and the host is always served before the display.

Every array access runs as a fixed phase sequence. First comes a bit-line precharge phase lasting `PRE_CYC` cycles. Then comes one cycle with the word line and the sense/write path enabled. A row fetched for the display lands in a line latch. A later display request for the same row is answered from that latch, without any precharge or word-line activity. A host write to the latched row drops the latch, so the next fetch of that row goes back to the array. The memory array is modelled behaviourally inside the block.

The request pins are one-cycle pulses. There is no ready signal. The back-pressure rule is that a client must not pulse a new request until its previous one has been acknowledged. Read data and line data are presented with their acknowledge and are valid only in that cycle.

Top module: `disp_ram_arb`

## Requirements
- R1: After reset, `host_ack`, `host_rvalid`, `scan_ack`, `pch_en` and `wl_en` are low and the line latch is empty, so the first display request after reset runs a full array access.
- R2: Every array access drives `pch_en` high for exactly `PRE_CYC` consecutive cycles, then `wl_en` high for exactly one cycle directly after. The two are never high together.
- R3: A host write stores `host_wdata` at `host_addr`, where the row is in the upper `RW` bits and the column in the lower `CLW` bits. When the arbiter is idle, `host_ack` pulses on the `PRE_CYC+2`-th rising edge after the edge that samples `host_req`.
- R4: A host read returns the stored word on `host_rdata`, with `host_rvalid` pulsing in the same cycle as `host_ack`. A write never raises `host_rvalid`.
- R5: A display request for an unlatched row returns the whole row on `scan_data`, with column c in bits [c*DW +: DW], in the cycle `scan_ack` pulses.
- R6: If host and display requests are sampled on the same edge, the host access runs first. The display access starts only after the host acknowledge, so with defaults `scan_ack` comes 8 edges after the request, and it carries the host's freshly written data.
- R7: A request that arrives while an access is in progress is held. It is launched once the current access completes, and it is never lost.
- R8: A display request for the row already in the valid line latch is acknowledged on the first edge after it is sampled. It returns the latched row and raises neither `pch_en` nor `wl_en`.
- R9: A host write to the latched row empties the latch. The next display request for that row runs a full array access and returns the new data.
- R10: A host write to any other row leaves the latch valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request pulse |
| host_we | input | 1 | 1 = write, 0 = read; sampled with `host_req` |
| host_addr | input | RW+CLW | Host word address {row, column} |
| host_wdata | input | DW | Host write data |
| host_ack | output | 1 | Host access complete pulse |
| host_rvalid | output | 1 | Read data valid pulse |
| host_rdata | output | DW | Read data |
| scan_req | input | 1 | Display line request pulse |
| scan_line | input | RW | Display row address |
| scan_ack | output | 1 | Line delivered pulse |
| scan_data | output | COLS*DW | Line data, column 0 in the low bits |
| pch_en | output | 1 | Bit-line precharge phase active |
| wl_en | output | 1 | Word-line / sense-write phase active |

## Verification
The bound checker watches the phase ordering on every cycle. It confirms that precharge precedes each word-line pulse, that the two phases never overlap, and that the word-line pulse lasts one cycle. It also checks that acknowledges follow a word-line pulse or a latch hit, that host precedence holds whenever both holds are pending at idle, and that a held display request survives a busy array. The directed scenarios alone show data correctness: stored words, full-row contents, latch invalidation by a same-row write versus retention on another row, and exact acknowledge latencies for coincident and late requests.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACT  = 2'd2
  } phase_e;
endpackage

// File: rtl/dra_hold.sv
module dra_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= 1'b0;
      q   <= '0;
    end else if (cap) begin
      vld <= 1'b1;
      q   <= din;
    end else if (take) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/dra_seq.sv
module dra_seq
  import dra_pkg::*;
#(
  parameter int PRE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic pch,
  output logic wl
);
  localparam int CW = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_CYC - 1);

  phase_e        ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_PRE;
          cnt <= '0;
        end
        PH_PRE: if (cnt == LAST) ph <= PH_ACT;
                else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle = (ph == PH_IDLE);
  assign pch  = (ph == PH_PRE);
  assign wl   = (ph == PH_ACT);
endmodule

// File: rtl/dra_array.sv
module dra_array #(
  parameter int ROWS = 8,
  parameter int COLS = 4,
  parameter int DW   = 8
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [$clog2(COLS)-1:0] col,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rword,
  output logic [COLS*DW-1:0]     rline
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [DW-1:0] mem_c [ROWS];
    always_ff @(posedge clk) begin
      if (we && col == ($clog2(COLS))'(c)) mem_c[row] <= wdata;
    end
    assign rline[c*DW +: DW] = mem_c[row];
  end

  assign rword = rline[col*DW +: DW];
endmodule

// File: rtl/disp_ram_arb.sv
module disp_ram_arb #(
  parameter int ROWS    = 8,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int PRE_CYC = 2,
  localparam int RW     = $clog2(ROWS),
  localparam int CLW    = $clog2(COLS),
  localparam int AW     = RW + CLW,
  localparam int LW     = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  input  logic          scan_req,
  input  logic [RW-1:0] scan_line,
  output logic          scan_ack,
  output logic [LW-1:0] scan_data,
  output logic          pch_en,
  output logic          wl_en
);
  localparam int HW = 1 + AW + DW;

  logic          h_v, s_v, idle;
  logic [HW-1:0] h_q;
  logic [RW-1:0] s_q;
  logic          take_h, take_s, s_hit, fast, start;

  logic          cur_host, cur_we;
  logic [RW-1:0] cur_row;
  logic [CLW-1:0] cur_col;
  logic [DW-1:0] cur_wd;

  logic          lat_v;
  logic [RW-1:0] lat_row;
  logic          arr_we;
  logic [DW-1:0] rword;
  logic [LW-1:0] rline;

  dra_hold #(.W(HW)) u_hhold (
    .clk(clk), .rst_n(rst_n), .cap(host_req),
    .din({host_we, host_addr, host_wdata}),
    .take(take_h), .vld(h_v), .q(h_q)
  );

  dra_hold #(.W(RW)) u_shold (
    .clk(clk), .rst_n(rst_n), .cap(scan_req), .din(scan_line),
    .take(take_s), .vld(s_v), .q(s_q)
  );

  assign take_h = idle & h_v;
  assign take_s = idle & ~h_v & s_v;
  assign s_hit  = lat_v & (lat_row == s_q);
  assign fast   = take_s & s_hit;
  assign start  = take_h | (take_s & ~s_hit);

  dra_seq #(.PRE_CYC(PRE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .idle(idle), .pch(pch_en), .wl(wl_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_host <= 1'b0;
      cur_we   <= 1'b0;
      cur_row  <= '0;
      cur_col  <= '0;
      cur_wd   <= '0;
    end else if (start) begin
      cur_host <= take_h;
      cur_we   <= take_h & h_q[HW-1];
      cur_row  <= take_h ? h_q[DW+CLW +: RW] : s_q;
      cur_col  <= h_q[DW +: CLW];
      cur_wd   <= h_q[DW-1:0];
    end
  end

  assign arr_we = wl_en & cur_host & cur_we;

  dra_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .row(cur_row), .col(cur_col),
    .wdata(cur_wd), .rword(rword), .rline(rline)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ack    <= 1'b0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      scan_ack    <= 1'b0;
      lat_v       <= 1'b0;
      lat_row     <= '0;
      scan_data   <= '0;
    end else begin
      host_ack    <= wl_en & cur_host;
      host_rvalid <= wl_en & cur_host & ~cur_we;
      if (wl_en & cur_host & ~cur_we) host_rdata <= rword;
      scan_ack    <= (wl_en & ~cur_host) | fast;
      if (wl_en & ~cur_host) begin
        lat_v     <= 1'b1;
        lat_row   <= cur_row;
        scan_data <= rline;
      end else if (arr_we && lat_v && lat_row == cur_row) begin
        lat_v     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dra_chk.sv
module dra_chk (
  input logic clk,
  input logic rst_n,
  input logic pch_en,
  input logic wl_en,
  input logic host_ack,
  input logic host_rvalid,
  input logic scan_ack,
  input logic h_pend,
  input logic s_pend,
  input logic idle,
  input logic cur_host
);
  p_pre_before_wl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_en) |-> $past(pch_en));
  p_wl_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |=> !wl_en);
  p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pch_en && wl_en));
  p_host_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(wl_en));
  p_rvalid_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> host_ack);
  p_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ack && scan_ack));
  p_host_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && h_pend && s_pend) |=> (pch_en && cur_host));
  p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pend && !idle) |=> s_pend);
  p_fast_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_ack && !$past(wl_en)) |-> $past(idle && s_pend && !h_pend));
endmodule

bind disp_ram_arb dra_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pch_en(pch_en), .wl_en(wl_en),
  .host_ack(host_ack), .host_rvalid(host_rvalid), .scan_ack(scan_ack),
  .h_pend(h_v), .s_pend(s_v), .idle(idle), .cur_host(cur_host)
);

// File: tb/disp_ram_arb_tb_top.sv
module disp_ram_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack, host_rvalid;
  logic [7:0]  host_rdata;
  logic        scan_req = 1'b0;
  logic [2:0]  scan_line = '0;
  logic        scan_ack;
  logic [31:0] scan_data;
  logic        pch_en, wl_en;

  int nchk = 0, nfail = 0;
  logic [7:0] model [8][4];

  int r_hl, r_sl, r_np, r_nw, r_rvk, r_ord;
  logic [7:0]  r_rd;
  logic [31:0] r_sd;

  always #4 clk = ~clk;

  disp_ram_arb dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .scan_req(scan_req), .scan_line(scan_line),
    .scan_ack(scan_ack), .scan_data(scan_data), .pch_en(pch_en), .wl_en(wl_en)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_row(input int r);
    logic [31:0] v;
    for (int c = 0; c < 4; c++) v[c*8 +: 8] = model[r][c];
    return v;
  endfunction

  // Sample k sees the state after the k-th edge counted from the request edge (edge 0 -> k=1).
  task automatic run(input bit hen, input bit we, input int row, input int col,
                     input logic [7:0] wd, input bit sen, input int sd, input int line);
    int prev_p;
    r_hl = -1; r_sl = -1; r_np = 0; r_nw = 0; r_rvk = -1; r_ord = 1;
    r_rd = '0; r_sd = '0; prev_p = 0;
    @(negedge clk);
    host_req = hen; host_we = we;
    host_addr = {row[2:0], col[1:0]}; host_wdata = wd;
    scan_req = sen && (sd == 0); scan_line = line[2:0];
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      host_req = 1'b0;
      scan_req = sen && (k == sd);
      if (pch_en) r_np++;
      if (wl_en) begin
        r_nw++;
        if (!prev_p) r_ord = 0;
      end
      prev_p = pch_en;
      if (host_ack && r_hl < 0) begin r_hl = k; r_rd = host_rdata; end
      if (host_rvalid && r_rvk < 0) r_rvk = k;
      if (scan_ack && r_sl < 0) begin r_sl = k; r_sd = scan_data; end
    end
    if (hen && we) model[row][col] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    chk(host_ack == 0 && host_rvalid == 0 && scan_ack == 0, "R1", "acks after reset",
        {host_ack, host_rvalid, scan_ack}, 0);
    chk(pch_en == 0 && wl_en == 0, "R1", "phases after reset", {pch_en, wl_en}, 0);
  endtask

  task automatic t_write(input int row, input int col, input logic [7:0] wd);
    run(1, 1, row, col, wd, 0, 0, 0);
    chk(r_hl == 5, "R3", "write ack latency", r_hl, 5);
    chk(r_np == 2 && r_nw == 1 && r_ord == 1, "R2", "phase counts/order",
        r_np * 100 + r_nw * 10 + r_ord, 211);
    chk(r_rvk < 0, "R4", "no rvalid on write", r_rvk, -1);
  endtask

  task automatic t_read(input int row, input int col);
    run(1, 0, row, col, 8'h00, 0, 0, 0);
    chk(r_hl == 5 && r_rvk == 5, "R4", "read ack/rvalid cycle", r_hl * 100 + r_rvk, 505);
    chk(r_rd == model[row][col], "R4", "read data", r_rd, model[row][col]);
  endtask

  task automatic t_scan(input int line, input bit expect_hit, input string rq);
    run(0, 0, 0, 0, 8'h00, 1, 0, line);
    if (expect_hit) begin
      chk(r_sl == 2, rq, "latched scan latency", r_sl, 2);
      chk(r_np == 0 && r_nw == 0, rq, "latched scan array idle", r_np * 10 + r_nw, 0);
    end else begin
      chk(r_sl == 5, rq, "array scan latency", r_sl, 5);
      chk(r_np == 2 && r_nw == 1 && r_ord == 1, "R2", "scan phases",
          r_np * 100 + r_nw * 10 + r_ord, 211);
    end
    chk(r_sd == exp_row(line), "R5", "scan row data", r_sd, exp_row(line));
  endtask

  task automatic t_coincident();
    run(1, 1, 2, 1, 8'hC3, 1, 0, 2);
    chk(r_hl == 5, "R6", "host first ack", r_hl, 5);
    chk(r_sl == 9, "R6", "scan after host ack", r_sl, 9);
    chk(r_sd == exp_row(2), "R6", "scan sees new write", r_sd, exp_row(2));
  endtask

  task automatic t_late_hold();
    run(1, 0, 0, 3, 8'h00, 1, 2, 3);
    chk(r_hl == 5 && r_rd == model[0][3], "R7", "host read during hold",
        r_hl, 5);
    chk(r_sl == 9, "R7", "held scan launched after access", r_sl, 9);
    chk(r_sd == exp_row(3), "R7", "held scan data", r_sd, exp_row(3));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        t_write(r, c, 8'((r * 37 + c * 11 + 5) ^ 8'h5A));     // R3
    t_read(1, 2);                                             // R4
    t_read(3, 0);
    t_scan(1, 0, "R1");                                       // first scan after reset
    t_scan(1, 1, "R8");
    t_write(3, 0, 8'h7E);
    t_scan(1, 1, "R10");                                      // other-row write keeps latch
    t_write(1, 2, 8'hA5);
    t_scan(1, 0, "R9");                                       // same-row write drops latch
    t_coincident();                                           // R6
    t_late_hold();                                            // R7, latch now row 3
    do_reset();
    t_reset_state();
    t_scan(3, 0, "R1");                                       // latch emptied by reset
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule